// File: doc/BRIEF.md
# Processor Run-State Supervisor

This block keeps track of the top-level run state of a processor core. Apart from the halted condition, the core is always either running normally or processing an exception. A STOP instruction puts it into a quiet substate of normal running, in which no bus cycles are issued. The block takes single-cycle event strobes from the rest of the core and moves between four states: normal, exception, stopped and halted. It drives a one-hot state vector, an enable that allows bus cycles, and a registered halt flag that external logic can observe.

Several events can start exception processing: an interrupt acknowledge, a traced instruction, a trap, a bus error, an address error, or a coprocessor exception request. Exception processing ends only when the handler's first instruction starts. If a bus error or an address error arrives during exception processing, the block treats it as a catastrophic double fault. It then locks into the halted state, and only an external reset releases it. A reset, from the asynchronous pin or from the synchronous reset strobe, puts the block in exception processing, which stands for the reset vector fetch, and clears the halt flag.

Top module: `rss_run_state`

## Requirements
- R1: An asserted `rst_n` (low) or a pulse on `ev_ext_reset` puts the state in exception processing, with `halt_flag` low and `bus_cycle_en` high. The strobe takes effect on the next clock edge, whatever the current state.
- R2: `run_state` is always one-hot. Bit 0 is normal, bit 1 is exception, bit 2 is stopped and bit 3 is halted.
- R3: In normal state, any exception source moves the state to exception on the next edge. The sources are interrupt acknowledge, trace, trap, bus error, address error and any `ev_cp_exc` bit. An exception source wins over a simultaneous `ev_stop`.
- R4: Exception state persists until `ev_handler_start` is seen without a fault. That edge moves the state to normal. Other exception sources, `ev_stop`, and any event while the state is not exception, change nothing here.
- R5: A bus error or an address error during exception state moves the state to halted on the next edge.
- R6: Halted state persists through every event except `ev_ext_reset`.
- R7: In normal state, `ev_stop` with no exception source moves the state to stopped.
- R8: Stopped state is left only on interrupt acknowledge or trace, which lead to exception state, or on reset. Trap, faults, coprocessor requests, stop and handler-start are ignored.
- R9: `bus_cycle_en` is low exactly when the state is stopped or halted.
- R10: `halt_flag` is a register that is high for every cycle the state is halted and low otherwise.
- R11: When several events come in the same cycle, reset wins over a fault, and a fault during exception state wins over handler-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_int_ack | input | 1 | Interrupt acknowledge strobe |
| ev_trace | input | 1 | Traced-instruction strobe |
| ev_trap | input | 1 | Trap strobe |
| ev_bus_err | input | 1 | Bus error strobe |
| ev_addr_err | input | 1 | Address error strobe |
| ev_cp_exc | input | CP_W | Coprocessor exception request strobes |
| ev_stop | input | 1 | STOP executed strobe |
| ev_handler_start | input | 1 | First handler instruction begins |
| ev_ext_reset | input | 1 | Synchronous external reset strobe |
| run_state | output | 4 | One-hot run state |
| bus_cycle_en | output | 1 | Bus cycles permitted |
| halt_flag | output | 1 | Registered halted indicator |

## Verification
The bench drives the block into each of the four states and then applies every combination of the ten event inputs, comparing the result against an arithmetic model of its own.

The sweep targets the following corner cases:
- **Fault together with handler-start.** A design with the wrong priority would return to normal instead of halting.
- **Reset together with a fault in halted or exception state.** A wrong priority here would leave the core locked.
- **Stop together with an exception source.** A design that got this wrong would go to sleep and miss the exception.
- **Faults and traps during stopped state.** A careless design would wake on them.
- **Halted state.** The sweep watches `bus_cycle_en` and `halt_flag`, where a design might let bus cycles resume or let the flag drop.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int RS_W       = 4;
  localparam int RS_NORMAL  = 0;
  localparam int RS_EXCEPT  = 1;
  localparam int RS_STOPPED = 2;
  localparam int RS_HALTED  = 3;

  function automatic logic [RS_W-1:0] rs_oh(input int idx);
    logic [RS_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // Priority: reset, halted lock, double fault, handler start, wake, exception, stop.
  function automatic logic [RS_W-1:0] rs_next(
    input logic [RS_W-1:0] cur,
    input logic            rst_req,
    input logic            fault,
    input logic            exc_req,
    input logic            wake,
    input logic            stop_req,
    input logic            hstart
  );
    logic [RS_W-1:0] n;
    n = cur;
    if (rst_req) begin
      n = rs_oh(RS_EXCEPT);
    end else if (cur[RS_HALTED]) begin
      n = cur;
    end else if (cur[RS_EXCEPT]) begin
      if (fault)       n = rs_oh(RS_HALTED);
      else if (hstart) n = rs_oh(RS_NORMAL);
    end else if (cur[RS_STOPPED]) begin
      if (wake) n = rs_oh(RS_EXCEPT);
    end else if (cur[RS_NORMAL]) begin
      if (exc_req)       n = rs_oh(RS_EXCEPT);
      else if (stop_req) n = rs_oh(RS_STOPPED);
    end else begin
      n = rs_oh(RS_EXCEPT);
    end
    return n;
  endfunction

  function automatic logic rs_bus_ok(input logic [RS_W-1:0] cur);
    return !(cur[RS_STOPPED] || cur[RS_HALTED]);
  endfunction
endpackage

// File: rtl/rss_event_class.sv
module rss_event_class #(
  parameter int CP_W = 2
) (
  input  logic            int_ack,
  input  logic            trace,
  input  logic            trap,
  input  logic            bus_err,
  input  logic            addr_err,
  input  logic [CP_W-1:0] cp_exc,
  input  logic            stop,
  input  logic            hstart_in,
  input  logic            ext_reset,
  output logic            fault,
  output logic            exc_req,
  output logic            wake,
  output logic            stop_req,
  output logic            hstart,
  output logic            rst_req
);
  logic [CP_W:0] cp_chain;
  assign cp_chain[0] = 1'b0;
  for (genvar g = 0; g < CP_W; g++) begin : g_cp_or
    assign cp_chain[g+1] = cp_chain[g] | cp_exc[g];
  end

  assign fault    = bus_err | addr_err;
  assign exc_req  = int_ack | trace | trap | fault | cp_chain[CP_W];
  assign wake     = int_ack | trace;
  assign stop_req = stop;
  assign hstart   = hstart_in;
  assign rst_req  = ext_reset;
endmodule

// File: rtl/rss_next_state.sv
module rss_next_state
  import rss_pkg::*;
(
  input  logic [RS_W-1:0] cur,
  input  logic            fault,
  input  logic            exc_req,
  input  logic            wake,
  input  logic            stop_req,
  input  logic            hstart,
  input  logic            rst_req,
  output logic [RS_W-1:0] nxt,
  output logic            nxt_halt
);
  always_comb begin
    nxt      = rs_next(cur, rst_req, fault, exc_req, wake, stop_req, hstart);
    nxt_halt = nxt[RS_HALTED];
  end
endmodule

// File: rtl/rss_state_reg.sv
module rss_state_reg
  import rss_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RS_W-1:0] nxt,
  input  logic            nxt_halt,
  output logic [RS_W-1:0] state_q,
  output logic            halt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= rs_oh(RS_EXCEPT);
      halt_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      halt_q  <= nxt_halt;
    end
  end
endmodule

// File: rtl/rss_run_state.sv
module rss_run_state
  import rss_pkg::*;
#(
  parameter int CP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_int_ack,
  input  logic            ev_trace,
  input  logic            ev_trap,
  input  logic            ev_bus_err,
  input  logic            ev_addr_err,
  input  logic [CP_W-1:0] ev_cp_exc,
  input  logic            ev_stop,
  input  logic            ev_handler_start,
  input  logic            ev_ext_reset,
  output logic [3:0]      run_state,
  output logic            bus_cycle_en,
  output logic            halt_flag
);
  logic            fault_w, exc_w, wake_w, stop_w, hstart_w, rst_w;
  logic [RS_W-1:0] nxt_w, state_w;
  logic            nxt_halt_w, halt_w;

  rss_event_class #(.CP_W(CP_W)) u_class (
    .int_ack   (ev_int_ack),
    .trace     (ev_trace),
    .trap      (ev_trap),
    .bus_err   (ev_bus_err),
    .addr_err  (ev_addr_err),
    .cp_exc    (ev_cp_exc),
    .stop      (ev_stop),
    .hstart_in (ev_handler_start),
    .ext_reset (ev_ext_reset),
    .fault     (fault_w),
    .exc_req   (exc_w),
    .wake      (wake_w),
    .stop_req  (stop_w),
    .hstart    (hstart_w),
    .rst_req   (rst_w)
  );

  rss_next_state u_next (
    .cur      (state_w),
    .fault    (fault_w),
    .exc_req  (exc_w),
    .wake     (wake_w),
    .stop_req (stop_w),
    .hstart   (hstart_w),
    .rst_req  (rst_w),
    .nxt      (nxt_w),
    .nxt_halt (nxt_halt_w)
  );

  rss_state_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (nxt_w),
    .nxt_halt (nxt_halt_w),
    .state_q  (state_w),
    .halt_q   (halt_w)
  );

  assign run_state    = state_w;
  assign bus_cycle_en = rs_bus_ok(state_w);
  assign halt_flag    = halt_w;

  AST_RESET_TO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext_reset |=> (run_state[RS_EXCEPT] && !halt_flag)); // R1
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_state) == 1); // R2
  AST_NORMAL_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_NORMAL] && exc_w && !ev_ext_reset) |=> run_state[RS_EXCEPT]); // R3
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_EXCEPT] && !ev_handler_start && !fault_w && !ev_ext_reset)
      |=> run_state[RS_EXCEPT]); // R4
  AST_DOUBLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_EXCEPT] && fault_w && !ev_ext_reset) |=> halt_flag); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_HALTED] && !ev_ext_reset) |=> run_state[RS_HALTED]); // R6
  AST_STOP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_NORMAL] && ev_stop && !exc_w && !ev_ext_reset)
      |=> run_state[RS_STOPPED]); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state[RS_STOPPED] && !wake_w && !ev_ext_reset) |=> run_state[RS_STOPPED]); // R8
  AST_NO_BUS_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halt_flag |-> !bus_cycle_en); // R9
  AST_HALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    run_state[RS_HALTED] |-> halt_flag); // R10
endmodule

// File: tb/rss_run_state_tb_top.sv
module rss_run_state_tb_top;
  localparam int CP_W = 2;
  localparam int EV_W = 8 + CP_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ev_int_ack = 0, ev_trace = 0, ev_trap = 0, ev_bus_err = 0;
  logic            ev_addr_err = 0, ev_stop = 0, ev_handler_start = 0, ev_ext_reset = 0;
  logic [CP_W-1:0] ev_cp_exc = '0;
  logic [3:0]      run_state;
  logic            bus_cycle_en, halt_flag;
  int              n_checks = 0;
  int              n_fails  = 0;

  always #5 clk = ~clk;

  rss_run_state #(.CP_W(CP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_int_ack(ev_int_ack), .ev_trace(ev_trace),
    .ev_trap(ev_trap), .ev_bus_err(ev_bus_err), .ev_addr_err(ev_addr_err),
    .ev_cp_exc(ev_cp_exc), .ev_stop(ev_stop), .ev_handler_start(ev_handler_start),
    .ev_ext_reset(ev_ext_reset), .run_state(run_state),
    .bus_cycle_en(bus_cycle_en), .halt_flag(halt_flag)
  );

  // event vector: 0 int_ack, 1 trace, 2 trap, 3 bus_err, 4 addr_err,
  // 5 stop, 6 handler_start, 7 ext_reset, 8.. coprocessor requests
  task automatic put(input logic [EV_W-1:0] e);
    ev_int_ack = e[0]; ev_trace = e[1]; ev_trap = e[2]; ev_bus_err = e[3];
    ev_addr_err = e[4]; ev_stop = e[5]; ev_handler_start = e[6];
    ev_ext_reset = e[7]; ev_cp_exc = e[EV_W-1:8];
  endtask

  task automatic step(input logic [EV_W-1:0] e);
    put(e);
    @(posedge clk);
    @(negedge clk);
    put('0);
  endtask

  // state codes: 0 normal, 1 exception, 2 stopped, 3 halted
  function automatic int model(input int s, input logic [EV_W-1:0] e);
    logic flt, any_src;
    flt = e[3] | e[4];
    any_src = e[0] | e[1] | e[2] | flt | (|e[EV_W-1:8]);
    if (e[7]) return 1;
    case (s)
      3: return 3;
      1: return flt ? 3 : (e[6] ? 0 : 1);
      2: return (e[0] | e[1]) ? 1 : 2;
      default: return any_src ? 1 : (e[5] ? 2 : 0);
    endcase
  endfunction

  function automatic string tag_of(input int s, input logic [EV_W-1:0] e);
    if (e[7] && (e[3] | e[4])) return "R11";
    if (e[7]) return "R1";
    case (s)
      3: return "R6";
      1: return (e[3] | e[4]) ? ((e[6]) ? "R11" : "R5") : "R4";
      2: return "R8";
      default: return (e[5] && !(|e[4:0]) && !(|e[EV_W-1:8])) ? "R7" : "R3";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic go_to(input int s);
    step(8'h80);
    if (s == 0 || s == 2) step(8'h40);
    if (s == 2) step(8'h20);
    if (s == 3) step(8'h08);
  endtask

  task automatic check_outputs(input string tag, input int exp_code);
    check(tag, int'(run_state), 1 << exp_code);
    check("R2", $countones(run_state), 1);
    check("R9", int'(bus_cycle_en), (exp_code < 2) ? 1 : 0);
    check("R10", int'(halt_flag), (exp_code == 3) ? 1 : 0);
  endtask

  initial begin
    #3_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R1", 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1", 1);
    for (int s = 0; s < 4; s++) begin
      go_to(s);
      check_outputs("R1", s);
      for (int v = 0; v < (1 << EV_W); v++) begin
        go_to(s);
        step(EV_W'(v));
        check_outputs(tag_of(s, EV_W'(v)), model(s, EV_W'(v)));
      end
    end
    go_to(3);
    for (int k = 0; k < 5; k++) begin
      step(EV_W'(8'h3F));
      check_outputs("R6", 3);
    end
    rst_n = 1'b0;
    #2;
    check_outputs("R1", 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule